// File: doc/BRIEF.md
# Multistage Self-Routing Packet Network

A clocked banyan network of `N_STAGES` stages that carries fixed-size packets from N = 2^N_STAGES sources to N sinks. Every source may offer one packet per cycle with an `N_STAGES`-bit destination tag. The network is a butterfly of 2x2 switch elements. Each element owns two output queues of depth `DEPTH`, and each stage uses one tag bit, most significant first, to pick between them. After the last stage, a packet sits in the queue whose index equals its tag. That queue drives the sink of the same index over a dedicated link, and the sink takes one packet per cycle.

New packets wait nowhere. An offered packet that cannot get a slot in its first-stage queue is discarded for good. Inside the network, transfers block instead of dropping, so no admitted packet is ever lost. Each packet carries the value of a free-running cycle counter from the cycle it was offered, so the sink side can measure latency. Each cycle the block reports how many new packets it admitted, how many it discarded and how many it delivered.

Top module: `banyan_net`

## Requirements
- R1: A packet offered with tag t leaves only at sink t. It carries as its stamp the number of clock edges between reset release and the cycle in which it was offered (modulo 2^16).
- R2: Stage s (counting from 0 at the sources) sends a packet to the queue of its 2x2 element whose index bit (N_STAGES-1-s) equals tag bit (N_STAGES-1-s), so every queued head agrees with its queue index on that bit.
- R3: A queue accepts, in a given cycle, at most as many packets as it has free slots at the start of that cycle; a slot freed by a departure in the same cycle is not reused until the next cycle. An offered packet refused at the first stage is discarded.
- R4: When two packets compete for a single free slot, the one coming from the element input whose steering bit is 0 wins. At the first stage the loser is discarded and never offered again by the network.
- R5: Every admitted packet is eventually delivered; nothing is dropped after the first stage.
- R6: Packets from one source to one sink are delivered in the order they were offered.
- R7: In an otherwise idle network, a packet offered in cycle c is presented at its sink in cycle c + N_STAGES.
- R8: Each cycle, `acc_cnt_o` equals the number of offered packets admitted in that cycle, `drop_cnt_o` the number offered but refused, and `dlv_cnt_o` the number of sinks with a valid packet.
- R9: Asserting `rst_ni` low empties every queue, clears all sink valids and counts, and restarts the stamp counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_valid_i | input | N | Source i offers a packet this cycle |
| src_tag_i | input | N*N_STAGES | Destination tag of source i in bits [i*N_STAGES +: N_STAGES] |
| sink_valid_o | output | N | Sink i receives a packet this cycle |
| sink_stamp_o | output | N*16 | Injection stamp for sink i in bits [i*16 +: 16] |
| acc_cnt_o | output | clog2(N+1) | New packets admitted this cycle |
| drop_cnt_o | output | clog2(N+1) | New packets discarded this cycle |
| dlv_cnt_o | output | clog2(N+1) | Packets delivered this cycle |

## Verification
The bench sends every source to one sink for two cycles in a row. A queue that reused a slot freed in the same cycle would admit part of the second wave when all of it should be dropped. A single-slot contention between two first-stage inputs with different tags shows which input won: favouring the wrong input would deliver to the wrong sink and leave an expected packet missing. Two full permutations (identity and reversal) confirm that the butterfly pairing routes every tag without conflict. A wrongly wired stage would send packets to the wrong sink. A reset in the middle of traffic must leave no ghost deliveries, and the stamp counter must restart, otherwise later stamps would not match.

// File: rtl/banyan_pkg.sv
package banyan_pkg;
  localparam int unsigned STAMP_W = 16;
  typedef logic [STAMP_W-1:0] stamp_t;
endpackage

// File: rtl/bn_queue.sv
module bn_queue #(
  parameter  int unsigned DEPTH = 2,
  parameter  int unsigned W     = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_a_i,
  input  logic [W-1:0]  data_a_i,
  input  logic          push_b_i,
  input  logic [W-1:0]  data_b_i,
  input  logic          pop_i,
  output logic          head_valid_o,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] wa, wb, rd_nx;

  // slot a first, then b: keeps the lower-position input ahead in order
  assign wa    = PW'((int'(rd_q) + int'(cnt_q)) % int'(DEPTH));
  assign wb    = PW'((int'(rd_q) + int'(cnt_q) + int'(push_a_i)) % int'(DEPTH));
  assign rd_nx = PW'((int'(rd_q) + 1) % int'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (push_a_i) mem_q[wa] <= data_a_i;
    if (push_b_i) mem_q[wb] <= data_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_i) rd_q <= rd_nx;
      cnt_q <= cnt_q + CW'(push_a_i) + CW'(push_b_i) - CW'(pop_i);
    end
  end

  assign head_valid_o = (cnt_q != '0);
  assign head_o       = mem_q[rd_q];
  assign count_o      = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= int'(DEPTH)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R5
endmodule

// File: rtl/bn_stage.sv
module bn_stage
  import banyan_pkg::*;
#(
  parameter  int unsigned N_STAGES = 3,
  parameter  int unsigned STAGE    = 0,
  parameter  int unsigned DEPTH    = 2,
  localparam int unsigned N        = 1 << N_STAGES,
  localparam int unsigned W        = N_STAGES + STAMP_W,
  localparam int unsigned CW       = $clog2(DEPTH + 1),
  localparam int unsigned BIT      = N_STAGES - 1 - STAGE,
  localparam int unsigned MASK     = 1 << BIT
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   feed_valid_i,
  input  logic [N*W-1:0] feed_pkt_i,
  input  logic [N-1:0]   pop_i,
  output logic [N-1:0]   take_o,
  output logic [N-1:0]   head_valid_o,
  output logic [N*W-1:0] head_pkt_o
);
  logic [N-1:0] gl, gh;

  for (genvar p = 0; p < N; p++) begin : g_q
    localparam int unsigned LO  = p & ~MASK;
    localparam int unsigned HI  = p | MASK;
    localparam logic        DIR = ((p & MASK) != 0);
    logic [W-1:0]  pkt_lo, pkt_hi;
    logic          want_lo, want_hi;
    logic [CW-1:0] cnt, free;

    assign pkt_lo  = feed_pkt_i[LO*W +: W];
    assign pkt_hi  = feed_pkt_i[HI*W +: W];
    assign want_lo = feed_valid_i[LO] && (pkt_lo[STAMP_W+BIT] == DIR);
    assign want_hi = feed_valid_i[HI] && (pkt_hi[STAMP_W+BIT] == DIR);
    // credit from start-of-cycle occupancy only: no path from downstream pops
    assign free    = CW'(DEPTH) - cnt;
    assign gl[p]   = want_lo && (free != '0);
    assign gh[p]   = want_hi && ((int'(free) >= 2) || ((free != '0) && !want_lo));

    bn_queue #(.DEPTH(DEPTH), .W(W)) u_queue (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_a_i     (gl[p]),
      .data_a_i     (pkt_lo),
      .push_b_i     (gh[p]),
      .data_b_i     (pkt_hi),
      .pop_i        (pop_i[p]),
      .head_valid_o (head_valid_o[p]),
      .head_o       (head_pkt_o[p*W +: W]),
      .count_o      (cnt)
    );

    AST_STEER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      head_valid_o[p] |-> head_pkt_o[p*W+STAMP_W+BIT] == DIR); // R2
  end

  for (genvar f = 0; f < N; f++) begin : g_take
    localparam int unsigned UP = f | MASK;
    localparam int unsigned DN = f & ~MASK;
    logic tb;
    assign tb = feed_pkt_i[f*W+STAMP_W+BIT];
    if ((f & MASK) != 0) begin : g_hi
      assign take_o[f] = tb ? gh[UP] : gh[DN];
    end else begin : g_lo
      assign take_o[f] = tb ? gl[UP] : gl[DN];
    end

    AST_TAKE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o[f] |-> feed_valid_i[f]); // R3
  end
endmodule

// File: rtl/banyan_net.sv
module banyan_net
  import banyan_pkg::*;
#(
  parameter  int unsigned N_STAGES = 3,
  parameter  int unsigned DEPTH    = 2,
  localparam int unsigned N        = 1 << N_STAGES,
  localparam int unsigned W        = N_STAGES + STAMP_W,
  localparam int unsigned CNT_W    = $clog2(N + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          src_valid_i,
  input  logic [N*N_STAGES-1:0] src_tag_i,
  output logic [N-1:0]          sink_valid_o,
  output logic [N*STAMP_W-1:0]  sink_stamp_o,
  output logic [CNT_W-1:0]      acc_cnt_o,
  output logic [CNT_W-1:0]      drop_cnt_o,
  output logic [CNT_W-1:0]      dlv_cnt_o
);
  stamp_t       now_q;
  logic [N-1:0]   bv [N_STAGES+1];
  logic [N*W-1:0] bp [N_STAGES+1];
  logic [N-1:0]   tk [N_STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  assign bv[0] = src_valid_i;
  for (genvar f = 0; f < N; f++) begin : g_src
    assign bp[0][f*W +: W] = {src_tag_i[f*N_STAGES +: N_STAGES], now_q};
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    bn_stage #(.N_STAGES(N_STAGES), .STAGE(s), .DEPTH(DEPTH)) u_stage (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .feed_valid_i (bv[s]),
      .feed_pkt_i   (bp[s]),
      .pop_i        (tk[s+1]),
      .take_o       (tk[s]),
      .head_valid_o (bv[s+1]),
      .head_pkt_o   (bp[s+1])
    );
  end

  // sinks never refuse: every last-stage head drains each cycle
  assign tk[N_STAGES]  = bv[N_STAGES];
  assign sink_valid_o  = bv[N_STAGES];

  for (genvar p = 0; p < N; p++) begin : g_sink
    assign sink_stamp_o[p*STAMP_W +: STAMP_W] = bp[N_STAGES][p*W +: STAMP_W];

    AST_SINK_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sink_valid_o[p] |-> bp[N_STAGES][p*W+STAMP_W +: N_STAGES] == N_STAGES'(p)); // R1
  end

  assign acc_cnt_o  = CNT_W'($countones(tk[0]));
  assign drop_cnt_o = CNT_W'($countones(src_valid_i) - $countones(tk[0]));
  assign dlv_cnt_o  = CNT_W'($countones(sink_valid_o));
endmodule

// File: tb/test_banyan_net.sv
module test_banyan_net;
  localparam int NS = 3;
  localparam int DP = 2;
  localparam int N = 8;
  localparam int CNT_W = 4;
  localparam int PER = 20;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_valid = '0;
  logic [N*NS-1:0] src_tag = '0;
  logic [N-1:0] sink_valid;
  logic [N*16-1:0] sink_stamp;
  logic [CNT_W-1:0] acc_cnt, drop_cnt, dlv_cnt;

  int errors = 0;
  int checks = 0;
  int unsigned cyc;
  logic [15:0] exp_q [N][$];

  always #(PER/2) clk = ~clk;

  banyan_net #(.N_STAGES(NS), .DEPTH(DP)) i_banyan_net (
    .clk_i(clk), .rst_ni(rst_n), .src_valid_i(src_valid), .src_tag_i(src_tag),
    .sink_valid_o(sink_valid), .sink_stamp_o(sink_stamp),
    .acc_cnt_o(acc_cnt), .drop_cnt_o(drop_cnt), .dlv_cnt_o(dlv_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*NS-1:0] tags_perm(input bit rev);
    logic [N*NS-1:0] v;
    for (int i = 0; i < N; i++) v[i*NS +: NS] = rev ? NS'(N-1-i) : NS'(i);
    return v;
  endfunction

  function automatic logic [N*NS-1:0] tags_all(input int t);
    logic [N*NS-1:0] v;
    for (int i = 0; i < N; i++) v[i*NS +: NS] = NS'(t);
    return v;
  endfunction

  // scoreboard monitor: pops expected stamps per sink as deliveries appear
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (sink_valid[i]) begin
          if (exp_q[i].size() == 0) chk("R1", $sformatf("unexpected delivery sink %0d", i), 1, 0);
          else chk("R1", $sformatf("stamp at sink %0d", i), sink_stamp[i*16 +: 16], exp_q[i].pop_front());
        end
      end
      chk("R8", "delivered count", dlv_cnt, $countones(sink_valid));
    end
  end

  task automatic drive(input logic [N-1:0] v, input logic [N*NS-1:0] t,
                       input int e_acc, input int e_drop, input string req,
                       output logic [15:0] st);
    @(negedge clk);
    src_valid = v;
    src_tag   = t;
    st = cyc[15:0];
    #5;
    chk(req, "accepted count", acc_cnt, e_acc);
    chk(req, "dropped count", drop_cnt, e_drop);
  endtask

  task automatic step(input int k);
    repeat (k) begin
      @(negedge clk);
      src_valid = '0;
    end
  endtask

  initial begin
    logic [15:0] st, sb;
    logic [N*NS-1:0] tv;
    #(PER*3 + 3);
    chk("R9", "sink valid in reset", sink_valid, 0);
    chk("R9", "accept count in reset", acc_cnt, 0);
    chk("R9", "delivered count in reset", dlv_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(2);

    // R7 single idle-network packet: source 3 -> sink 5
    tv = '0; tv[3*NS +: NS] = 3'd5;
    drive(8'b0000_1000, tv, 1, 0, "R7", st);
    exp_q[5].push_back(st);
    step(NS);
    #5;
    chk("R7", "sink valid after n cycles", sink_valid, 8'b0010_0000);
    chk("R7", "stamp after n cycles", sink_stamp[5*16 +: 16], st);
    step(4);

    // R2 two permutations back to back, all admitted
    drive('1, tags_perm(1'b0), 8, 0, "R2", st);
    for (int i = 0; i < N; i++) exp_q[i].push_back(st);
    drive('1, tags_perm(1'b1), 8, 0, "R2", st);
    for (int i = 0; i < N; i++) exp_q[N-1-i].push_back(st);
    step(10);
    for (int i = 0; i < N; i++) chk("R2", $sformatf("permutation pending sink %0d", i), exp_q[i].size(), 0);

    // R3 hotspot: first wave fills stage-0 queues, second wave is refused
    drive('1, tags_all(0), 8, 0, "R3", st);
    for (int i = 0; i < N; i++) exp_q[0].push_back(st);
    drive('1, tags_all(0), 0, 8, "R3", st);
    step(40);
    chk("R5", "hotspot packets pending", exp_q[0].size(), 0);

    // R4 single slot contention: source 0 (tag 0) beats source 4 (tag 1)
    tv = '0;
    drive(8'b0000_0001, tv, 1, 0, "R4", st);
    exp_q[0].push_back(st);
    tv[4*NS +: NS] = 3'd1;
    drive(8'b0001_0001, tv, 1, 1, "R4", sb);
    exp_q[0].push_back(sb);
    step(12);
    chk("R4", "winner delivered", exp_q[0].size(), 0);

    // R6 one source, one sink, three packets in order
    tv = '0; tv[2*NS +: NS] = 3'd6;
    for (int k = 0; k < 3; k++) begin
      drive(8'b0000_0100, tv, 1, 0, "R6", st);
      exp_q[6].push_back(st);
    end
    step(10);
    chk("R6", "in-order packets pending", exp_q[6].size(), 0);

    // R9 reset during traffic
    drive('1, tags_perm(1'b0), 8, 0, "R9", st);
    @(negedge clk);
    src_valid = '0;
    rst_n = 1'b0;
    #5;
    chk("R9", "sink valid under reset", sink_valid, 0);
    chk("R9", "accept count under reset", acc_cnt, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NS + 2; k++) begin
      step(1);
      #5;
      chk("R9", "no delivery after reset", sink_valid, 0);
    end
    tv = '0; tv[1*NS +: NS] = 3'd2;
    drive(8'b0000_0010, tv, 1, 0, "R9", st);
    exp_q[2].push_back(st);
    step(NS + 4);

    for (int i = 0; i < N; i++) chk("R5", $sformatf("final pending sink %0d", i), exp_q[i].size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PER * LIMIT);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule